// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block is the burst engine of a four-bank synchronous DRAM. A read or write command captures a bank and a starting column. From that edge on, the block issues one column per rising clock edge until the programmed number of beats is reached. The columns come in sequential order or in interleaved order. A small on-block array stands in for the cells. It takes write beats and feeds read beats into a latency pipeline, so read data appears a programmable number of clocks after its column is issued.

A mode command loads the burst length, burst order and read latency. Its operand rides on the column address lines. A stop command cuts a burst short. A new read or write command on any clock replaces the burst in progress at once. A per-beat mask input drops a write beat or blanks a read beat.

Top module: `sdram_burst_seq`

## Requirements
- R1: While `rst` is high at a rising edge, every output clears to zero. The mode returns to one beat, sequential order and latency 2.
- R2: A read (`cmd`=1) or write (`cmd`=2) sampled at edge k issues its first beat after edge k. That beat shows `col_valid`=1 and `col_addr` equal to the sampled column. Each later edge issues one more beat until the burst length is reached, then `col_valid` drops. `col_write` is 1 only on write beats. Outputs read zero when no beat is issued.
- R3: Sequential order: beat n uses column (start+n) modulo the burst length. Only the low log2(length) bits change; the upper column bits stay those of the start column.
- R4: Interleaved order: beat n uses the start column with its low log2(length) bits XORed with n.
- R5: A full-page burst is sequential. It wraps across the whole row and keeps issuing until a stop or a new command arrives.
- R6: The mode command (`cmd`=4) takes operand bits of `cmd_addr`: [2:0] length code (0,1,2,3 give 1,2,4,8 beats; 7 is full page), [3] order (1 = interleaved), [5:4] latency. An operand with length code 4–6, latency other than 2 or 3, or full page with interleaved order is rejected. The previous mode is kept.
- R7: A mode command sampled while a burst is active is ignored, and the burst continues.
- R8: A read beat issued at edge e shows `rd_valid`=1 and its cell data on `rd_data` after edge e+L−1, where L is the latency. So the first beat's data is presented during clock L counted from the read command.
- R9: An unmasked write beat stores `wr_data` into the cell at its bank and column. A write beat with `dqm`=1 leaves the cell unchanged.
- R10: A read beat issued with `dqm`=1 produces no data: in its output slot `rd_valid`=0 and `rd_data`=0. `rd_data` is zero whenever `rd_valid` is 0.
- R11: A stop command (`cmd`=3) issues no beat at its edge, and no further beats follow.
- R12: A read or write on any clock of an active burst ends that burst. The new burst's first beat follows at the next output cycle.
- R13: Every beat carries the bank latched from its command on `col_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | 0 idle, 1 read, 2 write, 3 stop, 4 mode load |
| cmd_bank | input | BANK_W | Bank select for read and write |
| cmd_addr | input | COL_W | Start column, or mode operand (COL_W ≥ 6) |
| wr_data | input | DW | Write beat data |
| dqm | input | 1 | Mask for the beat issued at this edge |
| col_valid | output | 1 | A beat was issued |
| col_write | output | 1 | The issued beat is a write |
| col_bank | output | BANK_W | Bank of the issued beat |
| col_addr | output | COL_W | Column of the issued beat |
| rd_valid | output | 1 | Read data present |
| rd_data | output | DW | Read data, zero when not valid |

## Verification
A beat counter or start column that is off shows on `col_addr` in the very next output cycle. A wrong end-of-burst decision shows as an extra or missing `col_valid` cycle just past the last beat. A corrupted mode register does not show until the next burst: that burst's length, order or data delay comes out wrong. A fault in the latency pipeline or the mask path shows on `rd_valid`/`rd_data` L−1 cycles after the read beat. A write-path fault appears only when the cell is read back later.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_STOP  = 3'd3,
    CMD_MODE  = 3'd4
  } cmd_e;

  localparam int OPER_W    = 6;
  localparam logic [2:0] LEN_FULL = 3'd7;

  function automatic logic oper_legal(input logic [OPER_W-1:0] w);
    logic len_ok;
    logic lat_ok;
    len_ok = (w[2:0] <= 3'd3) || ((w[2:0] == LEN_FULL) && !w[3]);
    lat_ok = (w[5:4] == 2'd2) || (w[5:4] == 2'd3);
    return len_ok && lat_ok;
  endfunction
endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
  import sbs_pkg::*;
#(
  parameter int COL_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              busy,
  input  logic [OPER_W-1:0] oper,
  output logic [COL_W-1:0]  len_mask,
  output logic              full_page,
  output logic              interleave,
  output logic [1:0]        latency
);
  logic [2:0] lcode_q;
  logic       ilv_q;
  logic [1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lcode_q <= 3'd0;
      ilv_q   <= 1'b0;
      lat_q   <= 2'd2;
    end else if (load && !busy && oper_legal(oper)) begin
      lcode_q <= oper[2:0];
      ilv_q   <= oper[3];
      lat_q   <= oper[5:4];
    end
  end

  always_comb begin
    full_page = (lcode_q == LEN_FULL);
    for (int i = 0; i < COL_W; i++)
      len_mask[i] = full_page || (i < int'(lcode_q));
  end

  assign interleave = ilv_q;
  assign latency    = lat_q;

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (load && busy) |=> ($stable(lcode_q) && $stable(ilv_q) && $stable(lat_q)));

  // R6
  lat_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (lat_q == 2'd2) || (lat_q == 2'd3));

  // R6
  ilv_full_chk: assert property (@(posedge clk) disable iff (rst)
    !(ilv_q && (lcode_q == LEN_FULL)));
endmodule

// File: rtl/sbs_col_gen.sv
module sbs_col_gen
  import sbs_pkg::*;
#(
  parameter int COL_W  = 6,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_addr,
  input  logic [COL_W-1:0]  len_mask,
  input  logic              full_page,
  input  logic              interleave,
  output logic              busy,
  output logic              beat_fire,
  output logic              beat_wr,
  output logic [BANK_W-1:0] beat_bank,
  output logic [COL_W-1:0]  beat_col,
  output logic              col_valid,
  output logic              col_write,
  output logic [BANK_W-1:0] col_bank,
  output logic [COL_W-1:0]  col_addr
);
  logic              act_q;
  logic              wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  start_q;
  logic [COL_W-1:0]  cnt_q;
  logic              new_cmd;
  logic              stop_cmd;
  logic [COL_W-1:0]  offset;

  assign new_cmd  = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign stop_cmd = (cmd == CMD_STOP);
  assign busy     = act_q;

  always_comb begin
    offset    = interleave ? (start_q ^ cnt_q) : (start_q + cnt_q);
    beat_fire = new_cmd || (act_q && !stop_cmd);
    if (new_cmd) begin
      beat_col  = cmd_addr;
      beat_bank = cmd_bank;
      beat_wr   = (cmd == CMD_WRITE);
    end else begin
      beat_col  = (start_q & ~len_mask) | (offset & len_mask);
      beat_bank = bank_q;
      beat_wr   = wr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      bank_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (new_cmd) begin
      act_q   <= (len_mask != '0);
      wr_q    <= (cmd == CMD_WRITE);
      bank_q  <= cmd_bank;
      start_q <= cmd_addr;
      cnt_q   <= {{(COL_W-1){1'b0}}, 1'b1};
    end else if (stop_cmd) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (!full_page && (cnt_q == len_mask))
        act_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_valid <= 1'b0;
      col_write <= 1'b0;
      col_bank  <= '0;
      col_addr  <= '0;
    end else begin
      col_valid <= beat_fire;
      col_write <= beat_fire && beat_wr;
      col_bank  <= beat_fire ? beat_bank : '0;
      col_addr  <= beat_fire ? beat_col : '0;
    end
  end

  // R11
  stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_STOP) |=> !col_valid);

  // R12
  new_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    new_cmd |=> (col_valid && (col_addr == $past(cmd_addr))));

  // R13
  new_bank_chk: assert property (@(posedge clk) disable iff (rst)
    new_cmd |=> (col_bank == $past(cmd_bank)));
endmodule

// File: rtl/sbs_rd_pipe.sv
module sbs_rd_pipe #(
  parameter int DW     = 8,
  parameter int ADDR_W = 8,
  parameter int MAX_L  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              wr,
  input  logic              mask,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [1:0]        latency,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int STG   = MAX_L - 1;

  logic [DW-1:0]          mem [DEPTH];
  logic [STG-1:0]         st_v;
  logic [STG-1:0][DW-1:0] st_d;
  logic                   sel_v;
  logic [DW-1:0]          sel_d;

  always_ff @(posedge clk) begin
    if (fire && wr && !mask)
      mem[addr] <= wdata;
    st_d[0] <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) st_v[0] <= 1'b0;
    else     st_v[0] <= fire && !wr && !mask;
  end

  generate
    for (genvar i = 1; i < STG; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st_v[i] <= 1'b0;
        else     st_v[i] <= st_v[i-1];
        st_d[i] <= st_d[i-1];
      end
    end
  endgenerate

  always_comb begin
    sel_v = st_v[0];
    sel_d = st_d[0];
    for (int i = 1; i < STG; i++) begin
      if (i == int'(latency) - 2) begin
        sel_v = st_v[i];
        sel_d = st_d[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= sel_v;
      rd_data  <= sel_v ? sel_d : '0;
    end
  end

  // R10
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));

  // R8
  lat2_chk: assert property (@(posedge clk) disable iff (rst)
    (latency == 2'd2 && $stable(latency)) |-> (rd_valid == $past(st_v[0])));
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int COL_W  = 6,
  parameter int BANK_W = 2,
  parameter int DW     = 8,
  parameter int MAX_L  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              dqm,
  output logic              col_valid,
  output logic              col_write,
  output logic [BANK_W-1:0] col_bank,
  output logic [COL_W-1:0]  col_addr,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  localparam int ADDR_W = BANK_W + COL_W;

  logic [COL_W-1:0]  len_mask;
  logic              full_page;
  logic              interleave;
  logic [1:0]        latency;
  logic              busy;
  logic              beat_fire;
  logic              beat_wr;
  logic [BANK_W-1:0] beat_bank;
  logic [COL_W-1:0]  beat_col;

  sbs_mode_reg #(.COL_W(COL_W)) u_mode (
    .clk        (clk),
    .rst        (rst),
    .load       (cmd == CMD_MODE),
    .busy       (busy),
    .oper       (cmd_addr[OPER_W-1:0]),
    .len_mask   (len_mask),
    .full_page  (full_page),
    .interleave (interleave),
    .latency    (latency)
  );

  sbs_col_gen #(.COL_W(COL_W), .BANK_W(BANK_W)) u_cols (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .cmd_bank   (cmd_bank),
    .cmd_addr   (cmd_addr),
    .len_mask   (len_mask),
    .full_page  (full_page),
    .interleave (interleave),
    .busy       (busy),
    .beat_fire  (beat_fire),
    .beat_wr    (beat_wr),
    .beat_bank  (beat_bank),
    .beat_col   (beat_col),
    .col_valid  (col_valid),
    .col_write  (col_write),
    .col_bank   (col_bank),
    .col_addr   (col_addr)
  );

  sbs_rd_pipe #(.DW(DW), .ADDR_W(ADDR_W), .MAX_L(MAX_L)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .fire     (beat_fire),
    .wr       (beat_wr),
    .mask     (dqm),
    .addr     ({beat_bank, beat_col}),
    .wdata    (wr_data),
    .latency  (latency),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/sdram_burst_seq_test.sv
module sdram_burst_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [1:0] cmd_bank = '0;
  logic [5:0] cmd_addr = '0;
  logic [7:0] wr_data = '0;
  logic       dqm = 1'b0;
  logic       col_valid, col_write, rd_valid;
  logic [1:0] col_bank;
  logic [5:0] col_addr;
  logic [7:0] rd_data;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  string tag = "R1";

  sdram_burst_seq uut (
    .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .wr_data(wr_data), .dqm(dqm), .col_valid(col_valid), .col_write(col_write),
    .col_bank(col_bank), .col_addr(col_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  int m_lcode, m_ilv, m_lat, m_bank, m_start, m_cnt;
  bit m_act, m_wr;
  int mem [256];
  bit slot_v [8];
  int slot_d [8];
  int cyc = 0;
  bit e_cv, e_cw, e_rv;
  int e_col, e_bank, e_rd;

  always @(posedge clk) begin
    int mask, col, idx, w;
    bit full, fire, old_act;
    if (rst) begin
      m_lcode = 0; m_ilv = 0; m_lat = 2; m_act = 0; m_wr = 0;
      m_bank = 0; m_start = 0; m_cnt = 0;
      e_cv = 0; e_cw = 0; e_col = 0; e_bank = 0; e_rv = 0; e_rd = 0;
      for (int i = 0; i < 8; i++) begin slot_v[i] = 0; slot_d[i] = 0; end
    end else begin
      idx = cyc % 8;
      e_rv = slot_v[idx]; e_rd = slot_d[idx];
      slot_v[idx] = 0; slot_d[idx] = 0;
      full = (m_lcode == 7);
      mask = full ? 63 : (1 << m_lcode) - 1;
      old_act = m_act;
      fire = 0; col = 0;
      if (cmd == 3'd1 || cmd == 3'd2) begin
        fire = 1; m_wr = (cmd == 3'd2); m_bank = cmd_bank; m_start = cmd_addr;
        col = cmd_addr; m_cnt = 1; m_act = (mask != 0);
      end else if (cmd == 3'd3) begin
        m_act = 0;
      end else if (m_act) begin
        fire = 1;
        w = m_ilv ? (m_start ^ m_cnt) : (m_start + m_cnt);
        col = ((m_start & ~mask) | (w & mask)) & 63;
        if (!full && m_cnt == mask) m_act = 0;
        m_cnt = (m_cnt + 1) % 64;
      end
      if (cmd == 3'd4 && !old_act) begin
        w = cmd_addr;
        if (((w & 7) <= 3 || ((w & 7) == 7 && ((w >> 3) & 1) == 0)) &&
            (((w >> 4) & 3) == 2 || ((w >> 4) & 3) == 3)) begin
          m_lcode = w & 7; m_ilv = (w >> 3) & 1; m_lat = (w >> 4) & 3;
        end
      end
      e_cv = fire; e_cw = fire && m_wr;
      e_col = fire ? col : 0; e_bank = fire ? m_bank : 0;
      if (fire && m_wr && !dqm) mem[m_bank*64 + col] = wr_data;
      if (fire && !m_wr) begin
        idx = (cyc + m_lat - 1) % 8;
        slot_v[idx] = !dqm;
        slot_d[idx] = dqm ? 0 : mem[m_bank*64 + col];
      end
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      tests++;
      if (col_valid !== e_cv || col_write !== e_cw || int'(col_addr) != e_col ||
          int'(col_bank) != e_bank || rd_valid !== e_rv || int'(rd_data) != e_rd) begin
        fails++;
        $display("FAIL %s cycle %0d: actual v=%0b w=%0b bank=%0d col=%0d rv=%0b rd=%0h expected v=%0b w=%0b bank=%0d col=%0d rv=%0b rd=%0h",
          tag, cyc, col_valid, col_write, col_bank, col_addr, rd_valid, rd_data,
          e_cv, e_cw, e_bank, e_col, e_rv, e_rd);
      end
    end
  end

  task automatic drive(input int c, input int b, input int a, input int d, input bit m);
    cmd = 3'(c); cmd_bank = 2'(b); cmd_addr = 6'(a); wr_data = 8'(d); dqm = m;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0);
  endtask

  task automatic set_mode(input int lc, input int ilv, input int lat);
    drive(4, 0, (lat << 4) | (ilv << 3) | lc, 0, 0);
    idle(1);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1: reset state at the ports
    tests++;
    if (col_valid !== 0 || col_write !== 0 || col_addr !== 0 || col_bank !== 0 ||
        rd_valid !== 0 || rd_data !== 0) begin
      fails++;
      $display("FAIL R1 reset: actual v=%0b rd=%0h expected 0 0", col_valid, rd_data);
    end
    rst = 0;
    idle(2);

    // R1 default mode: one beat, sequential, latency 2
    tag = "R1";
    drive(1, 0, 9, 0, 0); idle(4);

    // R5 + R9: fill every cell with full-page writes
    tag = "R5";
    set_mode(7, 0, 2);
    for (int b = 0; b < 4; b++) begin
      drive(2, b, 0, (b * 64) ^ 8'h5A, 0);
      for (int n = 1; n < 64; n++) drive(0, 0, 0, ((b * 64 + n) ^ 8'h5A) & 255, 0);
      drive(3, 0, 0, 0, 0);
      idle(1);
    end

    // R3, R4, R8: every legal length and order, both latencies
    for (int ilv = 0; ilv < 2; ilv++)
      for (int lc = 0; lc < 4; lc++) begin
        tag = ilv ? "R4" : "R3";
        set_mode(lc, ilv, 2 + ((lc + ilv) % 2));
        tag = (lc == 1) ? "R8" : (ilv ? "R4" : "R3");
        drive(1, lc, 13 + lc * 9, 0, 0);
        idle((1 << lc) + 4);
      end

    // R5: full-page read wraps across the row, ended by stop
    tag = "R5";
    set_mode(7, 0, 3);
    drive(1, 2, 60, 0, 0);
    idle(69);
    drive(3, 0, 0, 0, 0);
    idle(4);

    // R6: illegal operands rejected, BL8 interleaved latency 2 kept
    tag = "R6";
    set_mode(3, 1, 2);
    set_mode(7, 1, 2);
    set_mode(5, 0, 3);
    set_mode(2, 0, 1);
    drive(1, 1, 6, 0, 0);
    idle(12);

    // R7: mode load during a burst is ignored
    tag = "R7";
    drive(1, 3, 33, 0, 0);
    idle(2);
    drive(4, 0, (3 << 4) | 0, 0, 0);
    idle(8);
    drive(1, 0, 17, 0, 0);
    idle(12);

    // R9 and R10: masked write beats and masked read beats
    tag = "R9";
    set_mode(2, 0, 3);
    drive(2, 1, 20, 8'hA1, 0);
    drive(0, 0, 0, 8'hA2, 1);
    drive(0, 0, 0, 8'hA3, 0);
    drive(0, 0, 0, 8'hA4, 1);
    idle(3);
    drive(1, 1, 20, 0, 0);
    idle(6);
    tag = "R10";
    drive(1, 1, 20, 0, 0);
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1);
    idle(6);

    // R11: stop mid-burst for read and write
    tag = "R11";
    set_mode(3, 0, 2);
    drive(1, 3, 0, 0, 0);
    idle(2);
    drive(3, 0, 0, 0, 0);
    idle(5);
    drive(2, 2, 40, 8'h77, 0);
    drive(3, 0, 0, 0, 0);
    idle(3);
    drive(1, 2, 40, 0, 0);
    idle(11);

    // R12: interrupts on consecutive clocks
    tag = "R12";
    drive(1, 0, 8, 0, 0);
    drive(2, 0, 30, 8'hC3, 0);
    drive(0, 0, 0, 8'hC4, 0);
    drive(1, 1, 40, 0, 0);
    drive(1, 2, 50, 0, 0);
    drive(2, 3, 2, 8'h19, 0);
    idle(3);
    drive(1, 0, 30, 0, 0);
    idle(11);

    // R13 and R2: bank switching with short bursts
    tag = "R13";
    set_mode(1, 1, 3);
    for (int b = 0; b < 4; b++) drive(1, 3 - b, 7 * b + 1, 0, 0);
    idle(6);
    tag = "R2";
    set_mode(0, 0, 2);
    drive(2, 2, 5, 8'hEE, 0);
    drive(1, 2, 5, 0, 0);
    drive(1, 1, 5, 0, 0);
    idle(5);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule